// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of virtual-page to physical-frame mappings for an address translation path. Each stored mapping carries the identifier of the address space that owns it and a two-bit permission code. A lookup supplies a virtual page number, the current address-space identifier and the kind of access. One clock later the block reports whether a matching entry exists, the frame number it holds, and whether the access breaks the page's permission.

After a miss, the page-table walker outside this block writes the fetched mapping through the refill port. A refill that carries the same page and identifier as a live entry rewrites that entry in place. Any other refill takes the slot named by a round-robin pointer. Entries belonging to different address spaces can stay resident together. A context switch therefore needs no flush. Software can still invalidate the whole buffer, or only the entries of one address space.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses, with resp_hit_o=0, resp_fault_o=0 and resp_pfn_o=0. While rst_ni is low, all outputs are 0.
- R2: A lookup taken with lookup_valid_i=1 at a rising edge is answered on the outputs after that same edge, with resp_valid_o=1. Without a lookup, resp_valid_o, resp_hit_o and resp_fault_o are 0. When a valid entry holds both the presented page number and the presented identifier, resp_hit_o=1 and resp_pfn_o carries that entry's frame.
- R3: An entry whose page number matches but whose identifier differs from lookup_asid_i gives a miss, with resp_hit_o=0 and resp_pfn_o=0.
- R4: Permission codes are 00 read-only, 01 read-write, 10 execute-only and 11 no access. Access codes are 00 read, 01 write, 10 fetch and 11 reserved. Read-only permits reads only. Read-write permits reads and writes. Execute-only permits fetches only. Code 11 permits nothing, and access 11 is never permitted. A hit that is not permitted gives resp_hit_o=1, resp_fault_o=1 and resp_pfn_o=0.
- R5: A refill writes its page, identifier, frame and permission into the buffer. A lookup of that page and identifier on any later cycle hits and returns the written frame.
- R6: A refill whose page and identifier equal those of a valid entry overwrites that entry's frame and permission. It allocates no second copy and does not move the round-robin pointer.
- R7: Each refill that allocates a new entry writes the slot named by the round-robin pointer, then advances the pointer by one, wrapping after the last slot. Reset sets the pointer to slot 0, and flushes leave it unchanged. Starting from reset, the 17th distinct allocation evicts the 1st.
- R8: flush_all_i invalidates every entry. A refill presented in the same cycle is dropped.
- R9: flush_asid_i invalidates only the entries whose identifier equals flush_asid_id_i, and entries of other identifiers still hit. A refill presented in the same cycle is dropped. flush_all_i takes priority over flush_asid_i.
- R10: A lookup presented in the same cycle as a refill or a flush is answered from the contents the buffer held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_vpn_i | input | 20 | Virtual page number to translate |
| lookup_asid_i | input | 8 | Current address-space identifier |
| lookup_acc_i | input | 2 | Access type: 00 read, 01 write, 10 fetch |
| resp_valid_o | output | 1 | Lookup answer present |
| resp_hit_o | output | 1 | Matching entry found |
| resp_fault_o | output | 1 | Hit but access not permitted |
| resp_pfn_o | output | 16 | Frame number on a permitted hit, else 0 |
| refill_i | input | 1 | Write a mapping |
| refill_vpn_i | input | 20 | Page number of the mapping |
| refill_asid_i | input | 8 | Identifier of the mapping |
| refill_pfn_i | input | 16 | Frame number of the mapping |
| refill_perm_i | input | 2 | Permission: 00 RO, 01 RW, 10 XO, 11 none |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_asid_i | input | 1 | Invalidate the entries of one identifier |
| flush_asid_id_i | input | 8 | Identifier to invalidate |

## Verification
The bench goes after an identifier mismatch on a matching page. A design that ignored the tag would return another process's frame. It also rewrites a resident mapping and then runs exactly enough new allocations to wrap the pointer. A design that duplicated the entry, or advanced the pointer on a rewrite, would evict the wrong mapping, so a page that should still be resident would miss. Further directed cases apply each permission code against every access type, and place a lookup in the same cycle as a refill or a flush. A design that leaked a frame on a fault, or answered from post-update contents, would show a wrong frame or a wrong hit. Seeded random traffic over a small pool of keys compares every response with a bench model. It covers selective flushes that must spare other identifiers, and refills that must be dropped under a flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef logic [1:0] perm_t;
  typedef logic [1:0] acc_t;

  localparam perm_t PERM_RO = 2'b00;
  localparam perm_t PERM_RW = 2'b01;
  localparam perm_t PERM_XO = 2'b10;

  localparam acc_t ACC_RD = 2'b00;
  localparam acc_t ACC_WR = 2'b01;
  localparam acc_t ACC_FX = 2'b10;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][VPN_W-1:0]  vpn_i,
  input  logic [N-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]         key_vpn_i,
  input  logic [ASID_W-1:0]        key_asid_i,
  output logic [N-1:0]             match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  perm_t perm_i,
  input  acc_t  acc_i,
  output logic  allow_o
);
  always_comb begin
    case (perm_i)
      PERM_RO: allow_o = (acc_i == ACC_RD);
      PERM_RW: allow_o = (acc_i == ACC_RD) || (acc_i == ACC_WR);
      PERM_XO: allow_o = (acc_i == ACC_FX);
      default: allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_rr.sv
module tlb_rr #(
  parameter int N     = 16,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (alloc_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  assert_rr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_i |=> $stable(ptr_o));

  assert_rr_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> (ptr_o <= LAST) && (ptr_o != $past(ptr_o) || N == 1));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 16,
  parameter int ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [VPN_W-1:0]  lookup_vpn_i,
  input  logic [ASID_W-1:0] lookup_asid_i,
  input  logic [1:0]        lookup_acc_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_fault_o,
  output logic [PFN_W-1:0]  resp_pfn_o,
  input  logic              refill_i,
  input  logic [VPN_W-1:0]  refill_vpn_i,
  input  logic [ASID_W-1:0] refill_asid_i,
  input  logic [PFN_W-1:0]  refill_pfn_i,
  input  logic [1:0]        refill_perm_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_id_i
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]             valid_q;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][ASID_W-1:0] asid_q;
  logic [N-1:0][PFN_W-1:0]  pfn_q;
  logic [N-1:0][1:0]        perm_q;

  logic [N-1:0]     lk_match, rf_match, fl_sel, fl_left;
  logic [IDX_W-1:0] lk_idx, rf_idx, rr_ptr, wr_idx;
  logic             lk_hit, rf_hit, lk_allow, wr_en, alloc;

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
    .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(lookup_vpn_i), .key_asid_i(lookup_asid_i), .match_o(lk_match)
  );

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_cam (
    .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(refill_vpn_i), .key_asid_i(refill_asid_i), .match_o(rf_match)
  );

  for (genvar g = 0; g < N; g++) begin : g_fl
    assign fl_sel[g] = (asid_q[g] == flush_asid_id_i);
  end
  assign fl_left = valid_q & fl_sel;

  // one-hot to index; match vectors are at most one-hot
  always_comb begin
    lk_idx = '0;
    rf_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) lk_idx = lk_idx | IDX_W'(i);
      if (rf_match[i]) rf_idx = rf_idx | IDX_W'(i);
    end
  end

  assign lk_hit = |lk_match;
  assign rf_hit = |rf_match;

  tlb_perm u_perm (
    .perm_i(perm_q[lk_idx]), .acc_i(lookup_acc_i), .allow_o(lk_allow)
  );

  // flushes take precedence; a refill under flush is dropped
  assign wr_en  = refill_i && !flush_all_i && !flush_asid_i;
  assign alloc  = wr_en && !rf_hit;
  assign wr_idx = rf_hit ? rf_idx : rr_ptr;

  tlb_rr #(.N(N), .IDX_W(IDX_W)) u_rr (
    .clk_i(clk_i), .rst_ni(rst_ni), .alloc_i(alloc), .ptr_o(rr_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           valid_q <= '0;
    else if (flush_all_i)  valid_q <= '0;
    else if (flush_asid_i) valid_q <= valid_q & ~fl_sel;
    else if (wr_en)        valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q  <= '0;
      asid_q <= '0;
      pfn_q  <= '0;
      perm_q <= '0;
    end else if (wr_en) begin
      vpn_q[wr_idx]  <= refill_vpn_i;
      asid_q[wr_idx] <= refill_asid_i;
      pfn_q[wr_idx]  <= refill_pfn_i;
      perm_q[wr_idx] <= refill_perm_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_fault_o <= 1'b0;
      resp_pfn_o   <= '0;
    end else begin
      resp_valid_o <= lookup_valid_i;
      resp_hit_o   <= lookup_valid_i && lk_hit;
      resp_fault_o <= lookup_valid_i && lk_hit && !lk_allow;
      resp_pfn_o   <= (lookup_valid_i && lk_hit && lk_allow) ? pfn_q[lk_idx] : '0;
    end
  end

  assert_single_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match) && $onehot0(rf_match));

  assert_resp_timing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !resp_valid_o && !resp_hit_o && !resp_fault_o);

  assert_fault_no_pfn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o |-> resp_hit_o && (resp_pfn_o == '0));

  assert_miss_no_pfn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_hit_o |-> (resp_pfn_o == '0));

  assert_rewrite_no_grow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && rf_hit |=> $countones(valid_q) == $past($countones(valid_q)));

  assert_flush_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> valid_q == '0);

  assert_flush_asid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_asid_i && !flush_all_i |=>
      (flush_asid_id_i != $past(flush_asid_id_i)) || (fl_left == '0));
endmodule

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
  localparam int N = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 0;
  logic [19:0] lookup_vpn_i = 0;
  logic [7:0]  lookup_asid_i = 0;
  logic [1:0]  lookup_acc_i = 0;
  logic        resp_valid_o, resp_hit_o, resp_fault_o;
  logic [15:0] resp_pfn_o;
  logic        refill_i = 0;
  logic [19:0] refill_vpn_i = 0;
  logic [7:0]  refill_asid_i = 0;
  logic [15:0] refill_pfn_i = 0;
  logic [1:0]  refill_perm_i = 0;
  logic        flush_all_i = 0;
  logic        flush_asid_i = 0;
  logic [7:0]  flush_asid_id_i = 0;

  always #2.5 clk_i = ~clk_i;

  asid_tlb u0 (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit          m_v   [N];
  logic [19:0] m_vpn [N];
  logic [7:0]  m_asid[N];
  logic [15:0] m_pfn [N];
  logic [1:0]  m_perm[N];
  int          m_ptr = 0;

  function automatic bit allows(logic [1:0] perm, logic [1:0] acc);
    case (perm)
      2'b00:   return acc == 2'b00;
      2'b01:   return acc == 2'b00 || acc == 2'b01;
      2'b10:   return acc == 2'b10;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit lk, logic [19:0] vpn, logic [7:0] asid, logic [1:0] acc,
                      bit rf, logic [19:0] rvpn, logic [7:0] rasid, logic [15:0] rpfn,
                      logic [1:0] rperm, bit fa, bit fs, logic [7:0] fsid, string req);
    logic [18:0] exp;
    int hit_at;
    exp = '0;
    lookup_valid_i = lk; lookup_vpn_i = vpn; lookup_asid_i = asid; lookup_acc_i = acc;
    refill_i = rf; refill_vpn_i = rvpn; refill_asid_i = rasid;
    refill_pfn_i = rpfn; refill_perm_i = rperm;
    flush_all_i = fa; flush_asid_i = fs; flush_asid_id_i = fsid;
    // expectation from contents before the edge
    if (lk) begin
      exp[18] = 1'b1;
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) begin
          exp[17] = 1'b1;
          if (allows(m_perm[i], acc)) exp[15:0] = m_pfn[i];
          else exp[16] = 1'b1;
        end
    end
    if (fa) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (fs) begin
      for (int i = 0; i < N; i++) if (m_asid[i] == fsid) m_v[i] = 0;
    end else if (rf) begin
      hit_at = -1;
      for (int i = 0; i < N; i++)
        if (m_v[i] && m_vpn[i] == rvpn && m_asid[i] == rasid) hit_at = i;
      if (hit_at < 0) begin
        hit_at = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_v[hit_at] = 1; m_vpn[hit_at] = rvpn; m_asid[hit_at] = rasid;
      m_pfn[hit_at] = rpfn; m_perm[hit_at] = rperm;
    end
    @(negedge clk_i);
    check({resp_valid_o, resp_hit_o, resp_fault_o, resp_pfn_o} == exp, req,
          32'({resp_valid_o, resp_hit_o, resp_fault_o, resp_pfn_o}), 32'(exp));
    lookup_valid_i = 0; refill_i = 0; flush_all_i = 0; flush_asid_i = 0;
  endtask

  task automatic lk(logic [19:0] vpn, logic [7:0] asid, logic [1:0] acc, string req);
    step(1, vpn, asid, acc, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic rf(logic [19:0] vpn, logic [7:0] asid, logic [15:0] pfn,
                    logic [1:0] perm, string req);
    step(0, 0, 0, 0, 1, vpn, asid, pfn, perm, 0, 0, 0, req);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    check({resp_valid_o, resp_hit_o, resp_fault_o, resp_pfn_o} == '0, "R1 in reset",
          32'({resp_valid_o, resp_hit_o, resp_fault_o, resp_pfn_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    lk(20'h00010, 8'd1, 2'b00, "R1 empty miss");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");

    rf(20'h00010, 8'd1, 16'h1111, 2'b01, "R5 refill");
    lk(20'h00010, 8'd1, 2'b00, "R5 hit after refill");
    lk(20'h00010, 8'd1, 2'b01, "R4 rw write");
    lk(20'h00010, 8'd1, 2'b10, "R4 rw fetch fault");
    lk(20'h00010, 8'd1, 2'b11, "R4 reserved access");
    lk(20'h00010, 8'd2, 2'b00, "R3 asid mismatch");

    rf(20'h00020, 8'd2, 16'h2222, 2'b00, "R5 refill ro");
    lk(20'h00020, 8'd2, 2'b01, "R4 ro write fault");
    lk(20'h00020, 8'd2, 2'b00, "R4 ro read");
    rf(20'h00030, 8'd1, 16'h3333, 2'b10, "R5 refill xo");
    lk(20'h00030, 8'd1, 2'b10, "R4 xo fetch");
    lk(20'h00030, 8'd1, 2'b00, "R4 xo read fault");

    rf(20'h00010, 8'd1, 16'h4444, 2'b01, "R6 rewrite");
    lk(20'h00010, 8'd1, 2'b00, "R6 new frame");

    for (int i = 0; i < 13; i++) rf(20'h00100 + 20'(i), 8'd3, 16'h5000 + 16'(i), 2'b01, "R7 fill");
    rf(20'h00050, 8'd3, 16'h5555, 2'b01, "R7 wrap alloc");
    lk(20'h00010, 8'd1, 2'b00, "R7 oldest evicted");
    lk(20'h00020, 8'd2, 2'b00, "R7 second kept");

    step(1, 20'h00060, 8'd3, 2'b00, 1, 20'h00060, 8'd3, 16'h6666, 2'b01, 0, 0, 0, "R10 lookup with refill");
    lk(20'h00060, 8'd3, 2'b00, "R5 hit next cycle");

    step(0, 0, 0, 0, 1, 20'h00070, 8'd1, 16'h7777, 2'b01, 0, 1, 8'd3, "R9 flush asid drops refill");
    lk(20'h00050, 8'd3, 2'b00, "R9 flushed asid miss");
    lk(20'h00030, 8'd1, 2'b10, "R9 other asid kept");
    lk(20'h00070, 8'd1, 2'b00, "R9 refill dropped");

    step(1, 20'h00030, 8'd1, 2'b10, 1, 20'h00080, 8'd1, 16'h8888, 2'b01, 1, 1, 8'd2, "R10 lookup with flush");
    lk(20'h00030, 8'd1, 2'b10, "R8 flushed miss");
    lk(20'h00080, 8'd1, 2'b00, "R8 refill dropped");

    for (int k = 0; k < 4000; k++) begin
      logic [19:0] v, rv;
      logic [7:0]  fid;
      v   = (($urandom % 2) ? 20'hFFFF0 : 20'h00000) | 20'($urandom % 12);
      rv  = (($urandom % 2) ? 20'hFFFF0 : 20'h00000) | 20'($urandom % 12);
      fid = 8'($urandom % 4);
      step(($urandom % 10) < 7, v, 8'($urandom % 4), 2'($urandom % 4),
           ($urandom % 10) < 4, rv, 8'($urandom % 4), 16'($urandom), 2'($urandom % 4),
           ($urandom % 100) < 1, ($urandom % 100) < 3, fid, "R2 random");
    end
    finish_run();
  end
endmodule